// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block sits next to a small CPU core and owns the timing of taking an interrupt and coming back from one. The core reports instruction completion, the current program counter, the stack pointer, the global interrupt-enable flag and whether it is sleeping. The sequencer decides when a pending request may be taken. It then drives the two stack writes that save the program counter and the stack-pointer steps, and it loads the vector address into the program counter. On a return request it reads the two saved bytes back, steps the stack pointer up twice, reloads the program counter and sets the enable flag again.

Requests are taken only at an instruction boundary, or straight away while the core sleeps. A sleeping core first waits for an external oscillator-ready input and then spends a fixed number of extra cycles before entry begins. When the enable flag goes from low to high, one further instruction must complete before any request can be taken. The core and the stack memory stay outside the block: the stack is a byte port with an address and read and write strobes. The core applies the stack-pointer steps, the enable-flag updates and the program-counter load itself.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is asserted and right after it is released, busy_o, both stack strobes, both stack-pointer strobes, pc_load_o, both enable-flag strobes and irq_ack_o are all low.
- R2: An awake core has a request taken only in a cycle where insn_done_i is high, gie_i is high, at least one pending bit is set and the enable delay of R8 has run out. The cycle that takes the request is cycle A.
- R3: Of several pending bits, the lowest index n wins. irq_ack_o is one-hot with bit n set for exactly one cycle, in cycle A+1. The vector loaded is VEC_BASE + n.
- R4: Entry timing. In cycle A+1, stk_we_o and sp_dec_o are high, with stk_addr_o equal to sp_i and stk_wdata_o equal to PC[7:0]. In cycle A+2 the same happens for PC[15:8], at the stack pointer lowered by one. gie_clr_o is high in A+1. pc_load_o carries the vector in A+4. PC means the value of pc_i in cycle A.
- R5: With gie_i low, or with no insn_done_i while the core is awake, no request is taken, however long it stays pending.
- R6: With sleep_i high, a request is taken without insn_done_i. The block then stays busy without touching the stack until wake_ready_i is high in some cycle W. The first push follows in W+5 and the vector load in W+8.
- R7: A reti_i pulse in idle cycle R starts a return. stk_re_o and sp_inc_o are high in R+1 at address sp_i+1, where the high PC byte is read, and in R+2 at sp_i+1, where the low byte is read. In R+4 pc_load_o carries {high, low} and gie_set_o is high.
- R8: After gie_i rises, the next insn_done_i pulse never takes a request. The one after it may. This holds whether gie_i was raised by the core or by a return.
- R9: From A+1 or R+1 up to and including the load cycle, busy_o is high. insn_done_i, reti_i and new requests have no effect in that window, and busy_o is low in the cycle after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Current global interrupt-enable flag of the core |
| irq_pend_i | input | NUM_IRQ | Pending request bits, bit 0 highest priority |
| insn_done_i | input | 1 | An instruction completes this cycle |
| sleep_i | input | 1 | Core is in sleep |
| wake_ready_i | input | 1 | Oscillator start-up finished |
| reti_i | input | 1 | Return-from-interrupt request pulse |
| pc_i | input | 16 | Program counter to be saved |
| sp_i | input | SP_W | Current stack pointer |
| stk_rdata_i | input | 8 | Stack read data, valid in the cycle of the read |
| busy_o | output | 1 | A sequence is running, core is held |
| irq_ack_o | output | NUM_IRQ | One-hot acknowledge of the taken request |
| stk_we_o | output | 1 | Stack byte write strobe |
| stk_re_o | output | 1 | Stack byte read strobe |
| stk_addr_o | output | SP_W | Stack byte address |
| stk_wdata_o | output | 8 | Stack write data |
| sp_dec_o | output | 1 | Lower the stack pointer by one after this cycle |
| sp_inc_o | output | 1 | Raise the stack pointer by one after this cycle |
| pc_load_o | output | 1 | Load pc_load_val_o into the program counter |
| pc_load_val_o | output | 16 | Vector address or restored program counter |
| gie_clr_o | output | 1 | Clear the global enable flag |
| gie_set_o | output | 1 | Set the global enable flag |

## Verification
The hardest state to reach from the ports is the enable delay, because it only appears in the few cycles after gie_i rises. A request must already be pending when the rise happens, and the instruction strobes must fall either right on the rising cycle or some cycles later. The bench arranges this in three ways: the enable flag is raised by the bench while a request waits, it is raised late with a gap before the next instruction, and it is raised by a return while a second, lower-priority request is still pending. The sleep path is reached by holding sleep_i with no instruction strobe, and the bench withholds the oscillator-ready input for several cycles to show the stack stays untouched. Randomly chosen request sets, return addresses and stack pointers then exercise the priority, the byte order and the stack-pointer balance.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int PC_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE,
    ST_XTRA,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_ENT_WAIT,
    ST_VEC,
    ST_POP_HI,
    ST_POP_LO,
    ST_RET_WAIT,
    ST_RET_LD
  } seq_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_IRQ-1:0] grant_o
);
  // below[g]: some lower index is requesting
  logic [NUM_IRQ:0] below;
  assign below[0] = 1'b0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chain
    assign below[g+1]  = below[g] | req_i[g];
    assign grant_o[g]  = req_i[g] & ~below[g];
  end

  assign any_o = below[NUM_IRQ];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_enable_gate.sv
module irq_enable_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gie_i,
  input  logic insn_done_i,
  output logic allow_o
);
  logic gie_q, hold_q, hold_d, rise;

  assign rise = gie_i & ~gie_q;

  // one completed instruction must pass after enable rises
  always_comb begin
    hold_d = hold_q;
    if (insn_done_i)  hold_d = 1'b0;
    else if (rise)    hold_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      gie_q  <= gie_i;
      hold_q <= hold_d;
    end
  end

  assign allow_o = gie_i & ~rise & ~hold_q;
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int          NUM_IRQ   = 8,
  parameter int          IDX_W     = 3,
  parameter int          SP_W      = 16,
  parameter logic [15:0] VEC_BASE  = 16'h0010,
  parameter int          WAKE_XTRA = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               allow_i,
  input  logic               req_any_i,
  input  logic [IDX_W-1:0]   req_idx_i,
  input  logic [NUM_IRQ-1:0] req_grant_i,
  input  logic               insn_done_i,
  input  logic               sleep_i,
  input  logic               wake_ready_i,
  input  logic               reti_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [SP_W-1:0]    sp_i,
  input  logic [7:0]         stk_rdata_i,
  output logic               busy_o,
  output logic [NUM_IRQ-1:0] irq_ack_o,
  output logic               stk_we_o,
  output logic               stk_re_o,
  output logic [SP_W-1:0]    stk_addr_o,
  output logic [7:0]         stk_wdata_o,
  output logic               sp_dec_o,
  output logic               sp_inc_o,
  output logic               pc_load_o,
  output logic [PC_W-1:0]    pc_load_val_o,
  output logic               gie_clr_o,
  output logic               gie_set_o
);
  localparam int CNT_W = (WAKE_XTRA > 1) ? $clog2(WAKE_XTRA) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_XTRA - 1);

  seq_state_e           state_q, state_d;
  logic [IDX_W-1:0]     idx_q;
  logic [NUM_IRQ-1:0]   grant_q;
  logic [PC_W-1:0]      pc_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 take;

  assign take = allow_i & req_any_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (reti_i)                    state_d = ST_POP_HI;
        else if (take && insn_done_i)  state_d = ST_PUSH_LO;
        else if (take && sleep_i)      state_d = ST_WAKE;
      end
      ST_WAKE:     if (wake_ready_i) state_d = ST_XTRA;
      ST_XTRA:     if (cnt_q == CNT_LAST) state_d = ST_PUSH_LO;
      ST_PUSH_LO:  state_d = ST_PUSH_HI;
      ST_PUSH_HI:  state_d = ST_ENT_WAIT;
      ST_ENT_WAIT: state_d = ST_VEC;
      ST_VEC:      state_d = ST_IDLE;
      ST_POP_HI:   state_d = ST_POP_LO;
      ST_POP_LO:   state_d = ST_RET_WAIT;
      ST_RET_WAIT: state_d = ST_RET_LD;
      ST_RET_LD:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      grant_q <= '0;
      pc_q    <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && (state_d == ST_PUSH_LO || state_d == ST_WAKE)) begin
        idx_q   <= req_idx_i;
        grant_q <= req_grant_i;
        pc_q    <= pc_i;
      end
      if (state_q == ST_POP_HI) pc_q[15:8] <= stk_rdata_i;
      if (state_q == ST_POP_LO) pc_q[7:0]  <= stk_rdata_i;
      cnt_q <= (state_q == ST_XTRA) ? cnt_q + 1'b1 : '0;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign stk_we_o    = (state_q == ST_PUSH_LO) | (state_q == ST_PUSH_HI);
  assign sp_dec_o    = (state_q == ST_PUSH_LO) | (state_q == ST_PUSH_HI);
  assign stk_re_o    = (state_q == ST_POP_HI)  | (state_q == ST_POP_LO);
  assign sp_inc_o    = (state_q == ST_POP_HI)  | (state_q == ST_POP_LO);
  assign stk_addr_o  = stk_re_o ? sp_i + 1'b1 : sp_i;
  assign stk_wdata_o = (state_q == ST_PUSH_HI) ? pc_q[15:8] : pc_q[7:0];
  assign irq_ack_o   = (state_q == ST_PUSH_LO) ? grant_q : '0;
  assign gie_clr_o   = (state_q == ST_PUSH_LO);
  assign gie_set_o   = (state_q == ST_RET_LD);
  assign pc_load_o   = (state_q == ST_VEC) | (state_q == ST_RET_LD);
  assign pc_load_val_o = (state_q == ST_RET_LD) ? pc_q : VEC_BASE + PC_W'(idx_q);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          NUM_IRQ   = 8,
  parameter int          SP_W      = 16,
  parameter logic [15:0] VEC_BASE  = 16'h0010,
  parameter int          WAKE_XTRA = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gie_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic               insn_done_i,
  input  logic               sleep_i,
  input  logic               wake_ready_i,
  input  logic               reti_i,
  input  logic [15:0]        pc_i,
  input  logic [SP_W-1:0]    sp_i,
  input  logic [7:0]         stk_rdata_i,
  output logic               busy_o,
  output logic [NUM_IRQ-1:0] irq_ack_o,
  output logic               stk_we_o,
  output logic               stk_re_o,
  output logic [SP_W-1:0]    stk_addr_o,
  output logic [7:0]         stk_wdata_o,
  output logic               sp_dec_o,
  output logic               sp_inc_o,
  output logic               pc_load_o,
  output logic [15:0]        pc_load_val_o,
  output logic               gie_clr_o,
  output logic               gie_set_o
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic               allow, req_any;
  logic [IDX_W-1:0]   req_idx;
  logic [NUM_IRQ-1:0] req_grant;

  irq_prio_pick #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
    .req_i   (irq_pend_i),
    .any_o   (req_any),
    .idx_o   (req_idx),
    .grant_o (req_grant)
  );

  irq_enable_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gie_i       (gie_i),
    .insn_done_i (insn_done_i),
    .allow_o     (allow)
  );

  irq_seq_ctrl #(
    .NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W), .SP_W(SP_W),
    .VEC_BASE(VEC_BASE), .WAKE_XTRA(WAKE_XTRA)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .allow_i       (allow),
    .req_any_i     (req_any),
    .req_idx_i     (req_idx),
    .req_grant_i   (req_grant),
    .insn_done_i   (insn_done_i),
    .sleep_i       (sleep_i),
    .wake_ready_i  (wake_ready_i),
    .reti_i        (reti_i),
    .pc_i          (pc_i),
    .sp_i          (sp_i),
    .stk_rdata_i   (stk_rdata_i),
    .busy_o        (busy_o),
    .irq_ack_o     (irq_ack_o),
    .stk_we_o      (stk_we_o),
    .stk_re_o      (stk_re_o),
    .stk_addr_o    (stk_addr_o),
    .stk_wdata_o   (stk_wdata_o),
    .sp_dec_o      (sp_dec_o),
    .sp_inc_o      (sp_inc_o),
    .pc_load_o     (pc_load_o),
    .pc_load_val_o (pc_load_val_o),
    .gie_clr_o     (gie_clr_o),
    .gie_set_o     (gie_set_o)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int NUM_IRQ = 8,
  parameter int SP_W    = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               gie_i,
  input logic               insn_done_i,
  input logic               sleep_i,
  input logic               reti_i,
  input logic               busy_o,
  input logic [NUM_IRQ-1:0] irq_ack_o,
  input logic               stk_we_o,
  input logic               stk_re_o,
  input logic               pc_load_o,
  input logic               gie_clr_o,
  input logic               gie_set_o
);
  // R3
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_ack_o));

  // R4
  second_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_ack_o) |=> (stk_we_o && !gie_clr_o));

  // R4
  vec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_ack_o) |-> ##3 pc_load_o);

  // R7
  pop_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stk_re_o) |=> stk_re_o ##2 (pc_load_o && gie_set_o));

  // R7
  no_rw_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stk_we_o && stk_re_o));

  // R9
  load_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !busy_o);

  // R2
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(insn_done_i || sleep_i || reti_i));

  // R5
  gie_low_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !gie_i && !reti_i) |=> !busy_o);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NUM_IRQ(NUM_IRQ), .SP_W(SP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gie_i       (gie_i),
  .insn_done_i (insn_done_i),
  .sleep_i     (sleep_i),
  .reti_i      (reti_i),
  .busy_o      (busy_o),
  .irq_ack_o   (irq_ack_o),
  .stk_we_o    (stk_we_o),
  .stk_re_o    (stk_re_o),
  .pc_load_o   (pc_load_o),
  .gie_clr_o   (gie_clr_o),
  .gie_set_o   (gie_set_o)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam logic [15:0] VEC = 16'h0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // stimulus (driven by the main initial only)
  logic        insn_done = 0, sleep = 0, wake_ready = 0, reti = 0;
  logic [15:0] pc = 16'h0;
  logic [7:0]  pend_raise = 8'h0;
  logic        pend_clr = 0, gie_ld = 0, gie_ld_val = 0, sp_ld = 0;
  logic [15:0] sp_ld_val = 16'h0;
  logic        log_clr = 0;

  // core model
  logic        gie = 0;
  logic [15:0] sp = 16'h00F0;
  logic [7:0]  pend = 8'h0;
  logic [7:0]  mem [0:255];
  int          cyc = 0;

  // outputs
  logic        busy, we, re, sp_dec, sp_inc, ld, gclr, gset;
  logic [7:0]  ack, wdata, rdata;
  logic [15:0] addr, ld_val;

  // captured at negedge
  logic        m_we = 0, m_dec = 0, m_inc = 0, m_gset = 0, m_gclr = 0;
  logic [7:0]  m_ack = 0, m_wdata = 0;
  logic [15:0] m_addr = 0;

  // logs
  int          we_n, re_n, ld_n, ack_n, ld_cyc, ack_cyc, gclr_cyc, gset_cyc;
  int          we_cyc [0:3];
  int          re_cyc [0:3];
  logic [15:0] we_addr [0:3];
  logic [15:0] re_addr [0:3];
  logic [7:0]  we_data [0:3];
  logic [15:0] ld_v;
  logic [7:0]  ack_v;

  int nvec = 0, nbad = 0;

  assign rdata = mem[addr[7:0]];

  irq_entry_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gie_i(gie), .irq_pend_i(pend),
    .insn_done_i(insn_done), .sleep_i(sleep), .wake_ready_i(wake_ready),
    .reti_i(reti), .pc_i(pc), .sp_i(sp), .stk_rdata_i(rdata),
    .busy_o(busy), .irq_ack_o(ack), .stk_we_o(we), .stk_re_o(re),
    .stk_addr_o(addr), .stk_wdata_o(wdata), .sp_dec_o(sp_dec), .sp_inc_o(sp_inc),
    .pc_load_o(ld), .pc_load_val_o(ld_val), .gie_clr_o(gclr), .gie_set_o(gset)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (m_we) mem[m_addr[7:0]] <= m_wdata;
    if (sp_ld) sp <= sp_ld_val;
    else       sp <= sp - 16'(m_dec) + 16'(m_inc);
    if (gie_ld)      gie <= gie_ld_val;
    else if (m_gset) gie <= 1'b1;
    else if (m_gclr) gie <= 1'b0;
    if (pend_clr) pend <= 8'h0;
    else          pend <= (pend | pend_raise) & ~m_ack;
  end

  always @(negedge clk) begin
    m_we = we; m_dec = sp_dec; m_inc = sp_inc; m_gset = gset; m_gclr = gclr;
    m_ack = ack; m_wdata = wdata; m_addr = addr;
    if (log_clr) begin
      we_n = 0; re_n = 0; ld_n = 0; ack_n = 0;
      ld_cyc = -1; ack_cyc = -1; gclr_cyc = -1; gset_cyc = -1;
      ld_v = 16'h0; ack_v = 8'h0;
    end
    if (we) begin
      if (we_n < 4) begin we_cyc[we_n] = cyc; we_addr[we_n] = addr; we_data[we_n] = wdata; end
      we_n++;
    end
    if (re) begin
      if (re_n < 4) begin re_cyc[re_n] = cyc; re_addr[re_n] = addr; end
      re_n++;
    end
    if (ld) begin ld_n++; ld_cyc = cyc; ld_v = ld_val; end
    if (|ack) begin ack_n++; ack_cyc = cyc; ack_v = ack; end
    if (gclr) gclr_cyc = cyc;
    if (gset) gset_cyc = cyc;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic clr_log();
    log_clr = 1; tick(1); log_clr = 0;
  endtask

  function automatic int first_idx(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return 0;
  endfunction

  // enable on, enable delay consumed, pending cleared, stack pointer set
  task automatic prep(input logic [15:0] spv);
    pend_clr = 1; gie_ld = 1; gie_ld_val = 1; sp_ld = 1; sp_ld_val = spv;
    tick(1);
    pend_clr = 0; gie_ld = 0; sp_ld = 0; insn_done = 1;
    tick(1);
    insn_done = 0;
    tick(1);
  endtask

  task automatic check_entry(input int a, input logic [7:0] pat, input logic [15:0] pcv,
                             input logic [15:0] spv);
    int n = first_idx(pat);
    chk(ack_n == 1 && ack_cyc == a + 1, "R3 ack cycle", ack_cyc, a + 1);
    chk(ack_v == 8'(1 << n), "R3 ack winner", ack_v, 8'(1 << n));
    chk(we_n == 2 && we_cyc[0] == a + 1 && we_cyc[1] == a + 2, "R4 push cycles", we_cyc[0], a + 1);
    chk(we_addr[0] == spv && we_data[0] == pcv[7:0], "R4 low byte push", {we_addr[0], we_data[0]}, {spv, pcv[7:0]});
    chk(we_addr[1] == spv - 1 && we_data[1] == pcv[15:8], "R4 high byte push", {we_addr[1], we_data[1]}, {spv - 16'd1, pcv[15:8]});
    chk(gclr_cyc == a + 1, "R4 enable clear", gclr_cyc, a + 1);
    chk(ld_n == 1 && ld_cyc == a + 4, "R4 vector cycle", ld_cyc, a + 4);
    chk(ld_v == VEC + 16'(n), "R3 vector value", ld_v, VEC + 16'(n));
    chk(mem[spv[7:0]] == pcv[7:0] && mem[8'(spv - 1)] == pcv[15:8] && sp == spv - 2,
        "R4 stack image", {mem[8'(spv - 1)], mem[spv[7:0]]}, pcv);
  endtask

  task automatic entry(input logic [7:0] pat, input logic [15:0] pcv, input logic [15:0] spv);
    int a;
    prep(spv);
    clr_log();
    pend_raise = pat; tick(1); pend_raise = 8'h0;
    pc = pcv; insn_done = 1; a = cyc;
    tick(1); insn_done = 0;
    tick(8);
    check_entry(a, pat, pcv, spv);
  endtask

  task automatic ret(input logic [15:0] pcv, input logic [15:0] spv);
    int r;
    clr_log();
    reti = 1; r = cyc;
    tick(1); reti = 0;
    tick(8);
    chk(re_n == 2 && re_cyc[0] == r + 1 && re_cyc[1] == r + 2, "R7 pop cycles", re_cyc[0], r + 1);
    chk(re_addr[0] == spv - 1 && re_addr[1] == spv, "R7 pop addresses", {re_addr[0], re_addr[1]}, {spv - 16'd1, spv});
    chk(ld_n == 1 && ld_cyc == r + 4 && ld_v == pcv, "R7 restored pc", ld_v, pcv);
    chk(gset_cyc == r + 4 && gie && sp == spv, "R7 enable set and sp", {gie, sp}, {1'b1, spv});
  endtask

  initial begin
    int a, w;
    void'($urandom(32'h5EED_0042));
    clr_log();
    tick(2);
    // R1 during reset
    chk(!busy && !we && !re && !ld && ack == 0 && !gclr && !gset && !sp_dec && !sp_inc,
        "R1 in reset", {busy, we, re, ld}, 0);
    rst_n = 1;
    tick(2);
    chk(!busy && !we && !re && !ld && ack == 0 && !gclr && !gset, "R1 after reset", {busy, we, re, ld}, 0);

    // R2 R3 R4 R7 directed
    entry(8'h01, 16'hBEEF, 16'h0080);
    ret(16'hBEEF, 16'h0080);
    entry(8'h80, 16'h1234, 16'h00FF);
    ret(16'h1234, 16'h00FF);

    // R5: enable low
    prep(16'h0080);
    gie_ld = 1; gie_ld_val = 0; tick(1); gie_ld = 0;
    clr_log();
    pend_raise = 8'h02; tick(1); pend_raise = 8'h0;
    insn_done = 1; tick(4); insn_done = 0; tick(4);
    chk(ack_n == 0 && !busy && we_n == 0, "R5 enable low", ack_n, 0);

    // R5: enable high, no instruction boundary
    prep(16'h0080);
    clr_log();
    pend_raise = 8'h04; tick(1); pend_raise = 8'h0;
    tick(6);
    chk(ack_n == 0 && !busy, "R5 mid-instruction", ack_n, 0);
    pc = 16'h4321; insn_done = 1; a = cyc; tick(1); insn_done = 0; tick(8);
    check_entry(a, 8'h04, 16'h4321, 16'h0080);
    ret(16'h4321, 16'h0080);

    // R8: enable rises with the next instruction on the same cycle
    prep(16'h0090);
    gie_ld = 1; gie_ld_val = 0; tick(1); gie_ld = 0;
    pend_raise = 8'h08; tick(2); pend_raise = 8'h0;
    clr_log();
    pc = 16'h0A0B;
    gie_ld = 1; gie_ld_val = 1; tick(1); gie_ld = 0;
    insn_done = 1; tick(1); insn_done = 0; tick(3);
    chk(ack_n == 0 && !busy, "R8 first instruction after enable", ack_n, 0);
    insn_done = 1; a = cyc; tick(1); insn_done = 0; tick(8);
    check_entry(a, 8'h08, 16'h0A0B, 16'h0090);
    ret(16'h0A0B, 16'h0090);

    // R8: enable rises, instruction completes later
    prep(16'h0090);
    gie_ld = 1; gie_ld_val = 0; tick(1); gie_ld = 0;
    pend_raise = 8'h10; tick(2); pend_raise = 8'h0;
    clr_log();
    gie_ld = 1; gie_ld_val = 1; tick(1); gie_ld = 0;
    tick(3);
    insn_done = 1; tick(1); insn_done = 0; tick(3);
    chk(ack_n == 0 && !busy, "R8 delayed instruction after enable", ack_n, 0);
    insn_done = 1; a = cyc; tick(1); insn_done = 0; tick(8);
    check_entry(a, 8'h10, 16'h0A0B, 16'h0090);
    ret(16'h0A0B, 16'h0090);

    // R6: entry from sleep
    prep(16'h00A0);
    clr_log();
    pc = 16'h7766; sleep = 1;
    pend_raise = 8'h20; tick(1); pend_raise = 8'h0;
    a = cyc;
    tick(3);
    chk(busy && we_n == 0 && ack_n == 0, "R6 waits for oscillator", {busy, 8'(we_n)}, {1'b1, 8'h0});
    wake_ready = 1; sleep = 0; w = cyc;
    tick(1); wake_ready = 0;
    tick(10);
    chk(we_n == 2 && we_cyc[0] == w + 5, "R6 first push after wake", we_cyc[0], w + 5);
    chk(ld_n == 1 && ld_cyc == w + 8 && ld_v == VEC + 16'd5, "R6 vector after wake", ld_cyc, w + 8);
    chk(ack_v == 8'h20 && we_data[0] == 8'h66 && we_data[1] == 8'h77, "R6 saved pc",
        {we_data[1], we_data[0]}, 16'h7766);
    ret(16'h7766, 16'h00A0);

    // R9: strobes ignored while busy
    prep(16'h0070);
    clr_log();
    pend_raise = 8'h01; tick(1); pend_raise = 8'h0;
    pc = 16'h2468; insn_done = 1; a = cyc; tick(1); insn_done = 0;
    tick(1);
    reti = 1; insn_done = 1; pend_raise = 8'h02; tick(1); reti = 0; insn_done = 0; pend_raise = 8'h0;
    tick(1);
    chk(busy, "R9 busy during entry", busy, 1);
    tick(5);
    chk(re_n == 0 && we_n == 2 && ld_n == 1, "R9 no extra activity", {8'(re_n), 8'(we_n), 8'(ld_n)}, 24'h000201);
    chk(ld_cyc == a + 4 && !busy, "R9 idle after load", ld_cyc, a + 4);
    pend_clr = 1; tick(1); pend_clr = 0;
    ret(16'h2468, 16'h0070);

    // R8 after return, back to back
    entry(8'h06, 16'hCAFE, 16'h00C0);
    ret(16'hCAFE, 16'h00C0);
    clr_log();
    insn_done = 1; tick(1); insn_done = 0; tick(4);
    chk(ack_n == 0 && !busy, "R8 one instruction after return", ack_n, 0);
    insn_done = 1; a = cyc; tick(1); insn_done = 0; tick(8);
    check_entry(a, 8'h04, 16'hCAFE, 16'h00C0);
    ret(16'hCAFE, 16'h00C0);

    // random entries and returns (R2 R3 R4 R7)
    for (int k = 0; k < 40; k++) begin
      logic [7:0]  pat = 8'($urandom);
      logic [15:0] pcv = 16'($urandom);
      logic [15:0] spv = 16'h0040 + 16'($urandom % 128);
      if (pat == 8'h0) pat = 8'h40;
      entry(pat, pcv, spv);
      ret(pcv, spv);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule